// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block is the main feedback divider of a synthesiser that uses an external two-modulus prescaler. It is clocked by the prescaler output. It runs a 7-bit swallow counter and a 10-bit main counter, and both counters take their start values from the configuration inputs. The block drives a modulus-select line back to the prescaler. While the swallow count is still running, the line stays low and the prescaler divides by P+1. After the swallow count ends, the line goes high and the prescaler divides by P until the main count ends. Both counters then restart together, so the whole chain divides the oscillator by M·P + A.

At the end of each division cycle the block emits a terminal pulse one clock wide. This pulse is the divided signal passed on to the phase detector. A synchronous reload request first clears both counters to a quiet zero state for one clock. On the next clock it starts a fresh cycle from the current configuration. This gives the loop a known restart point when the channel changes. The block also flags a cycle whose loaded values cannot produce the intended ratio.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `rst` is high, and in the clock that follows it, `mod_ctrl`, `term_pulse` and `cfg_err` are low. The first rising edge with `rst` low starts a division cycle.
- R2: A division cycle lasts exactly M clocks, where M is the value of `cfg_m` taken at the cycle start. Consecutive terminal pulses are therefore M clocks apart.
- R3: At clock position k of a cycle (k = 0 … M−1), `mod_ctrl` is 1 exactly when k ≥ A, where A is the value of `cfg_a` taken at the cycle start. The line is therefore low at the start of every cycle with A > 0. It never falls inside a cycle, and it is high at the terminal position whenever M > A.
- R4: When A = 0, `mod_ctrl` is high for every position of the cycle, including position 0.
- R5: `term_pulse` is high only at position M−1 and lasts one clock.
- R6: When `reload_req` is high at a rising edge, the next clock is a zero state with `mod_ctrl`, `term_pulse` and `cfg_err` low. The following edge starts a new cycle from the current configuration. This holds at any position, the terminal one included.
- R7: `cfg_a` and `cfg_m` are sampled only when a cycle starts. Changes made inside a cycle do not affect that cycle.
- R8: `cfg_err` is high for the whole of a cycle whose loaded values satisfy M < 8 or M ≤ A, and low for every other cycle.
- R9: The boundary settings A = 127 with M = 128, and M = 1023, divide correctly under R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_a | input | 7 | Swallow count A |
| cfg_m | input | 10 | Main count M |
| reload_req | input | 1 | Synchronous clear-and-reload request |
| mod_ctrl | output | 1 | Prescaler modulus select (1 = divide by P) |
| term_pulse | output | 1 | One-clock pulse at the end of each cycle |
| cfg_err | output | 1 | Current cycle has M < 8 or M ≤ A |

## Verification
Two events can land on the same clock. The first is a reload request in the clock that carries the terminal pulse: the bench raises the request exactly as the last position of a cycle is shown. It expects that pulse to remain visible, then one zero-state clock, and then a full new cycle, with no second cycle start in between. The second is a cycle start with A = 0 directly after a terminal pulse: the modulus line must already be high in position 0 instead of dropping for one clock. A scoreboard judges every clock of both cases against a position-by-position model built from the requirements.

// File: rtl/psd_pkg.sv
package psd_pkg;

    // Default widths and limits of the divider
    parameter int unsigned SW_WIDTH  = 7;
    parameter int unsigned MN_WIDTH  = 10;
    parameter int unsigned MN_LOWEST = 8;

    // Sequencer phase: quiet zero state or counting
    typedef enum logic {
        PH_ZERO = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Per-clock commands from the sequencer to the counters
    typedef struct packed {
        logic clear;
        logic load;
        logic run;
    } ctl_t;

endpackage

// File: rtl/psd_sequencer.sv
module psd_sequencer
    import psd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic reload_req,
    input  logic main_done,
    output ctl_t ctl,
    output logic running
);

    phase_e phase_q;
    logic   clear_now;

    assign clear_now = rst | reload_req;

    always_ff @(posedge clk) begin
        if (clear_now) begin
            phase_q <= PH_ZERO;
        end else begin
            phase_q <= PH_RUN;
        end
    end

    assign running = (phase_q == PH_RUN);

    // A load starts a cycle: out of the zero state, or after the final position
    always_comb begin
        ctl.clear = clear_now;
        ctl.load  = !clear_now && ((phase_q == PH_ZERO) || main_done);
        ctl.run   = !clear_now && (phase_q == PH_RUN) && !main_done;
    end

endmodule

// File: rtl/psd_swallow_ctr.sv
module psd_swallow_ctr #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] load_val,
    output logic         mod_ctrl
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] left_q;
    logic         mc_q;

    always_ff @(posedge clk) begin
        if (clear) begin
            left_q <= '0;
            mc_q   <= 1'b0;
        end else if (load) begin
            left_q <= load_val;
            mc_q   <= (load_val == '0);
        end else if (run) begin
            if (left_q != '0) begin
                left_q <= left_q - ONE;
            end
            // High from the position at which the swallow count has expired
            mc_q <= (left_q <= ONE);
        end
    end

    assign mod_ctrl = mc_q;

endmodule

// File: rtl/psd_main_ctr.sv
module psd_main_ctr #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         load,
    input  logic         run,
    input  logic         running,
    input  logic [W-1:0] load_val,
    output logic         done
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (clear) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val - ONE;
        end else if (run) begin
            left_q <= left_q - ONE;
        end
    end

    // The final position of a counting cycle
    assign done = running && (left_q == '0);

endmodule

// File: rtl/psd_cfg_check.sv
module psd_cfg_check #(
    parameter int unsigned SW_W   = 7,
    parameter int unsigned MN_W   = 10,
    parameter int unsigned MN_MIN = 8
) (
    input  logic            clk,
    input  logic            clear,
    input  logic            load,
    input  logic [SW_W-1:0] sw_val,
    input  logic [MN_W-1:0] mn_val,
    output logic            err
);

    localparam logic [MN_W-1:0] MN_FLOOR = MN_W'(MN_MIN);

    logic bad_now;
    logic err_q;

    assign bad_now = (mn_val < MN_FLOOR) || (mn_val <= MN_W'(sw_val));

    always_ff @(posedge clk) begin
        if (clear) begin
            err_q <= 1'b0;
        end else if (load) begin
            err_q <= bad_now;
        end
    end

    assign err = err_q;

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter int unsigned SW_W   = SW_WIDTH,
    parameter int unsigned MN_W   = MN_WIDTH,
    parameter int unsigned MN_MIN = MN_LOWEST
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SW_W-1:0] cfg_a,
    input  logic [MN_W-1:0] cfg_m,
    input  logic            reload_req,
    output logic            mod_ctrl,
    output logic            term_pulse,
    output logic            cfg_err
);

    ctl_t ctl;
    logic running;
    logic main_done;

    psd_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .reload_req (reload_req),
        .main_done  (main_done),
        .ctl        (ctl),
        .running    (running)
    );

    psd_swallow_ctr #(.W(SW_W)) u_swallow (
        .clk      (clk),
        .clear    (ctl.clear),
        .load     (ctl.load),
        .run      (ctl.run),
        .load_val (cfg_a),
        .mod_ctrl (mod_ctrl)
    );

    psd_main_ctr #(.W(MN_W)) u_main (
        .clk      (clk),
        .clear    (ctl.clear),
        .load     (ctl.load),
        .run      (ctl.run),
        .running  (running),
        .load_val (cfg_m),
        .done     (main_done)
    );

    psd_cfg_check #(.SW_W(SW_W), .MN_W(MN_W), .MN_MIN(MN_MIN)) u_check (
        .clk    (clk),
        .clear  (ctl.clear),
        .load   (ctl.load),
        .sw_val (cfg_a),
        .mn_val (cfg_m),
        .err    (cfg_err)
    );

    assign term_pulse = main_done;

endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
    parameter int unsigned SW_W   = 7,
    parameter int unsigned MN_W   = 10,
    parameter int unsigned MN_MIN = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [SW_W-1:0] cfg_a,
    input logic [MN_W-1:0] cfg_m,
    input logic            reload_req,
    input logic            mod_ctrl,
    input logic            term_pulse,
    input logic            cfg_err
);

    logic in_bad;
    logic starts;

    assign in_bad = (cfg_m < MN_W'(MN_MIN)) || (cfg_m <= MN_W'(cfg_a));
    assign starts = term_pulse && !reload_req;

    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (rst)
        reload_req |=> (!mod_ctrl && !term_pulse && !cfg_err)); // R6

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        (starts && (cfg_a != '0)) |=> !mod_ctrl); // R3

    AST_ZERO_SWALLOW_HIGH: assert property (@(posedge clk) disable iff (rst)
        (starts && (cfg_a == '0)) |=> mod_ctrl); // R4

    AST_MC_NO_MIDFALL: assert property (@(posedge clk) disable iff (rst)
        $fell(mod_ctrl) |-> ($past(term_pulse) || $past(reload_req) || $past(rst))); // R3

    AST_TERM_MC_HIGH: assert property (@(posedge clk) disable iff (rst)
        (term_pulse && !cfg_err) |-> mod_ctrl); // R3

    AST_TERM_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (term_pulse && !cfg_err) |=> (!term_pulse || cfg_err)); // R5

    AST_ERR_AT_LOAD: assert property (@(posedge clk) disable iff (rst)
        starts |=> (cfg_err == $past(in_bad))); // R8

endmodule

bind pulse_swallow_div psd_checker #(
    .SW_W   (SW_W),
    .MN_W   (MN_W),
    .MN_MIN (MN_MIN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_a      (cfg_a),
    .cfg_m      (cfg_m),
    .reload_req (reload_req),
    .mod_ctrl   (mod_ctrl),
    .term_pulse (term_pulse),
    .cfg_err    (cfg_err)
);

// File: tb/tb_pulse_swallow_div.sv
`timescale 1ns/1ps
module tb_pulse_swallow_div;

    typedef struct {
        bit    mc;
        bit    tp;
        bit    err;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] cfg_a = '0;
    logic [9:0] cfg_m = '0;
    logic       reload_req = 1'b0;
    logic       mod_ctrl;
    logic       term_pulse;
    logic       cfg_err;

    int   total = 0;
    int   bad = 0;
    bit   finished = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    pulse_swallow_div dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_a      (cfg_a),
        .cfg_m      (cfg_m),
        .reload_req (reload_req),
        .mod_ctrl   (mod_ctrl),
        .term_pulse (term_pulse),
        .cfg_err    (cfg_err)
    );

    function automatic bit exp_bad(int a, int m);
        return (m < 8) || (m <= a);
    endfunction

    // Expected per-position outputs of one cycle (R2, R3, R4, R5, R8)
    task automatic push_cycle(int a, int m, string grp);
        for (int k = 0; k < m; k++) begin
            exp_t e;
            e.mc  = (k >= a);
            e.tp  = (k == m - 1);
            e.err = exp_bad(a, m);
            e.req = (k == m - 1) ? {grp, "/R5"} : ((a == 0) ? {grp, "/R4"} : {grp, "/R3"});
            q.push_back(e);
        end
    endtask

    // Called just after a cycle start: new values change mid-cycle (R7)
    task automatic step_cycle(int a, int m, string grp);
        @(negedge clk); #1;
        cfg_a = 7'(a);
        cfg_m = 10'(m);
        push_cycle(a, m, grp);
        while (q.size() > m) begin
            @(negedge clk); #1;
        end
        @(posedge clk);
    endtask

    // Reload once only rem items of the current cycle remain (R6)
    task automatic reload_at(int rem, int a, int m, string grp);
        exp_t z;
        while (q.size() > rem) begin
            @(negedge clk); #1;
        end
        q.delete();
        cfg_a = 7'(a);
        cfg_m = 10'(m);
        reload_req = 1'b1;
        z.mc = 0; z.tp = 0; z.err = 0; z.req = "R6";
        q.push_back(z);
        push_cycle(a, m, grp);
        @(negedge clk); #1;
        reload_req = 1'b0;
        @(posedge clk);
    endtask

    task automatic check_bit(string req, logic got, logic want, string what);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, got, want);
        end
    endtask

    // Monitor: pop one expectation per clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (mod_ctrl !== e.mc || term_pulse !== e.tp) begin
                bad++;
                $display("FAIL %s mc/tp actual=%0b/%0b expected=%0b/%0b",
                         e.req, mod_ctrl, term_pulse, e.mc, e.tp);
            end
            total++;
            if (cfg_err !== e.err) begin
                bad++;
                $display("FAIL R8 cfg_err actual=%0b expected=%0b", cfg_err, e.err);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cfg_a = 7'd3;
        cfg_m = 10'd10;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R1: quiet outputs while reset is held
        check_bit("R1", mod_ctrl, 1'b0, "mod_ctrl");
        check_bit("R1", term_pulse, 1'b0, "term_pulse");
        check_bit("R1", cfg_err, 1'b0, "cfg_err");
        rst = 1'b0;
        push_cycle(3, 10, "R1");
        @(posedge clk);

        step_cycle(0, 8, "R4");        // A = 0 straight after a terminal pulse
        step_cycle(127, 128, "R9");    // largest swallow count
        step_cycle(5, 1023, "R9");     // largest main count
        step_cycle(2, 5, "R8");        // M below the floor
        step_cycle(8, 8, "R8");        // M equal to A
        step_cycle(4, 12, "R7");

        reload_at(7, 6, 9, "R6");      // mid-cycle reload
        step_cycle(1, 8, "R2");
        reload_at(0, 0, 9, "R6");      // reload in the terminal clock
        step_cycle(3, 10, "R7");

        while (q.size() != 0) begin
            @(negedge clk); #1;
        end
        check_bit("R2", 1'b0, 1'b0, "queue drained");
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule